// File: doc/BRIEF.md
# Cascaded Level-2 Interrupt Aggregator

This block sits between a set of level-sensitive interrupt sources and a parent interrupt controller. Each connected source has an enable bit held in a bus-accessible register. The sources that are both active and enabled are captured in a status register. Each aggregated output to the parent is the OR of the status bits selected by that output's routing mask. Nothing needs to be acknowledged: a status bit stays set for as long as its source stays active, and clears when the source goes low.

A small group of low-numbered sources can be forwarded. A forwarded source skips the aggregation logic and drives a dedicated parent line of its own, with no enable gating and no register stage. Forwarded sources never appear in the status register or on an aggregated output.

When wake support is built in and the suspend input is high, the enable value in effect is widened to include the forward set and an externally supplied wake set. The stored enable value is never overwritten, so it takes effect again as soon as suspend is released. The routing masks, the forward set, the source count and wake support are fixed when the block is elaborated.

Top module: `l2irq_aggregator`

## Requirements
- R1: The enable register is at byte offset 0x00. A write stores the bits for the connected sources (bits 0 to NUM_SRC-1) and a read returns them. Bits at and above NUM_SRC always read 0.
- R2: An enable bit of 1 lets its source through and an enable bit of 0 blocks it. A blocked source never appears in status and never asserts an aggregated output.
- R3: The status register is at offset 0x04. It reads as (active sources) AND (effective enable), with forwarded sources removed. Writes to 0x04 change nothing.
- R4: Aggregated output k is high exactly when status AND routing mask k is nonzero. The default masks are 0xEB8 for output 0 and 0x140 for output 1.
- R5: Source i below NUM_FWD is forwarded when FWD_MASK bit i is 1. It then drives fwd_irq_o[i] directly, without enable gating or a register stage, and is absent from status and from the aggregated outputs. A direct line whose forward bit is 0 stays 0. The default FWD_MASK is 3'b111.
- R6: Bit positions with no connected source (12 to 31 by default) read 0 in status and never assert an output, whatever is written or supplied as the wake set.
- R7: Status is level-sensitive. A status bit clears in the cycle after its source goes low, with no bus access.
- R8: After reset, the enable register holds the forward set (0x7 by default) and all other sources are disabled. Status and the aggregated outputs are 0.
- R9: With WAKE_EN set and suspend_i high, the effective enable is the stored enable OR the forward set OR wake_mask_i. A read of 0x00 during suspend still returns the stored value. When suspend_i falls, the stored value alone applies again.
- R10: A change on a non-forwarded source shows in status and on the aggregated outputs at the first rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Byte offset (0x00 enable, 0x04 status) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the access, 0 when not selected |
| suspend_i | input | 1 | Suspend indication that widens the enable to the wake set |
| wake_mask_i | input | 32 | Wake-active source set used during suspend |
| agg_irq_o | output | NUM_OUT | Registered aggregated lines to the parent controller |
| fwd_irq_o | output | NUM_FWD | Direct lines for forwarded sources |

## Verification
On every clock cycle the assertions check four things. Status never shows a source that was blocked or inactive in the previous cycle. An aggregated output is never high unless a status bit in its mask is set. A write to the status offset leaves the enable register unchanged. During suspend, the effective enable never drops a bit of the stored enable. The exact status value and output values for each source pattern under several enable settings come only from the bench's sweep, which runs over two forward configurations. The same holds for the reset contents, the one-edge latency, and the suspend-and-restore sequence.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 3'h0;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'h4;

  typedef logic [REG_W-1:0] word_t;

  typedef struct packed {
    logic              sel;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    word_t             wdata;
  } bus_req_t;
endpackage

// File: rtl/l2irq_rst_sync.sv
module l2irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/l2irq_regs.sv
module l2irq_regs
  import l2irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 12,
  parameter int unsigned NUM_FWD = 3,
  parameter logic [NUM_FWD-1:0] FWD_MASK = 3'b111,
  parameter bit WAKE_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bus_req_t           req_i,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic               suspend_i,
  input  word_t              wake_i,
  output logic [NUM_SRC-1:0] en_q_o,
  output logic [NUM_SRC-1:0] en_eff_o,
  output word_t              rdata_o
);
  localparam logic [NUM_SRC-1:0] FWD_EXT = NUM_SRC'(FWD_MASK);

  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] en_d;
  logic               en_we;

  // next-state for the enable register
  always_comb begin
    en_we = req_i.sel & req_i.wr & (req_i.addr == ADDR_ENABLE);
    en_d  = req_i.wdata[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= FWD_EXT;
    else if (en_we) en_q <= en_d;
  end

  // suspend overlay: stored value is left untouched, so release restores it
  generate
    if (WAKE_EN) begin : g_wake
      always_comb begin
        en_eff_o = suspend_i ? (en_q | FWD_EXT | wake_i[NUM_SRC-1:0]) : en_q;
      end
    end else begin : g_nowake
      logic unused_suspend;
      always_comb begin
        unused_suspend = suspend_i ^ (^wake_i[NUM_SRC-1:0]);
        en_eff_o       = en_q;
      end
    end
  endgenerate

  // read mux, combinational, zero outside selected reads
  always_comb begin
    rdata_o = '0;
    if (req_i.sel && !req_i.wr) begin
      case (req_i.addr)
        ADDR_ENABLE: rdata_o = REG_W'(en_q);
        ADDR_STATUS: rdata_o = REG_W'(status_i);
        default:     rdata_o = '0;
      endcase
    end
  end

  generate
    if (NUM_SRC < REG_W) begin : g_hi_unused
      logic unused_hi;
      assign unused_hi = (^req_i.wdata[REG_W-1:NUM_SRC]) ^ (^wake_i[REG_W-1:NUM_SRC]);
    end
  endgenerate

  assign en_q_o = en_q;
endmodule

// File: rtl/l2irq_route.sv
module l2irq_route
  import l2irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 12,
  parameter int unsigned NUM_OUT = 2,
  parameter logic [NUM_OUT*REG_W-1:0] ROUTE_MASKS = {32'h0000_0140, 32'h0000_0EB8},
  parameter logic [NUM_SRC-1:0] L2_MASK = 12'hFF8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] en_eff_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_OUT-1:0] agg_o
);
  logic [NUM_SRC-1:0] status_d;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_OUT-1:0] agg_d;
  logic [NUM_OUT-1:0] agg_q;

  always_comb begin
    status_d = src_i & en_eff_i & L2_MASK;
  end

  // one reduction per parent line, all from the same next-state status
  generate
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
      localparam logic [NUM_SRC-1:0] ROUTE_K = ROUTE_MASKS[k*REG_W +: NUM_SRC];
      always_comb begin
        agg_d[k] = |(status_d & ROUTE_K);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      agg_q    <= '0;
    end else begin
      status_q <= status_d;
      agg_q    <= agg_d;
    end
  end

  assign status_o = status_q;
  assign agg_o    = agg_q;
endmodule

// File: rtl/l2irq_fwd.sv
module l2irq_fwd #(
  parameter int unsigned NUM_SRC = 12,
  parameter int unsigned NUM_FWD = 3,
  parameter logic [NUM_FWD-1:0] FWD_MASK = 3'b111
) (
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_FWD-1:0] fwd_o
);
  generate
    for (genvar i = 0; i < NUM_FWD; i++) begin : g_line
      if (FWD_MASK[i]) begin : g_pass
        assign fwd_o[i] = src_i[i];
      end else begin : g_tie
        assign fwd_o[i] = 1'b0;
      end
    end
    if (NUM_SRC > NUM_FWD) begin : g_rest
      logic unused_rest;
      assign unused_rest = ^src_i[NUM_SRC-1:NUM_FWD];
    end
  endgenerate
endmodule

// File: rtl/l2irq_aggregator.sv
module l2irq_aggregator
  import l2irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 12,
  parameter int unsigned NUM_OUT = 2,
  parameter int unsigned NUM_FWD = 3,
  parameter logic [NUM_OUT*REG_W-1:0] ROUTE_MASKS = {32'h0000_0140, 32'h0000_0EB8},
  parameter logic [NUM_FWD-1:0] FWD_MASK = 3'b111,
  parameter bit WAKE_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel_i,
  input  logic               bus_wr_i,
  input  logic [2:0]         bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  input  logic               suspend_i,
  input  logic [31:0]        wake_mask_i,
  output logic [NUM_OUT-1:0] agg_irq_o,
  output logic [NUM_FWD-1:0] fwd_irq_o
);
  localparam logic [NUM_SRC-1:0] FWD_EXT = NUM_SRC'(FWD_MASK);
  localparam logic [NUM_SRC-1:0] L2_MASK = ~FWD_EXT;

  logic               rst_sync_n;
  bus_req_t           req;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] en_eff;
  logic [NUM_SRC-1:0] status_q;

  l2irq_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    req.sel   = bus_sel_i;
    req.wr    = bus_wr_i;
    req.addr  = bus_addr_i;
    req.wdata = bus_wdata_i;
  end

  l2irq_regs #(
    .NUM_SRC (NUM_SRC),
    .NUM_FWD (NUM_FWD),
    .FWD_MASK(FWD_MASK),
    .WAKE_EN (WAKE_EN)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_i    (req),
    .status_i (status_q),
    .suspend_i(suspend_i),
    .wake_i   (wake_mask_i),
    .en_q_o   (en_q),
    .en_eff_o (en_eff),
    .rdata_o  (bus_rdata_o)
  );

  l2irq_route #(
    .NUM_SRC    (NUM_SRC),
    .NUM_OUT    (NUM_OUT),
    .ROUTE_MASKS(ROUTE_MASKS),
    .L2_MASK    (L2_MASK)
  ) u_route (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .src_i   (src_i),
    .en_eff_i(en_eff),
    .status_o(status_q),
    .agg_o   (agg_irq_o)
  );

  l2irq_fwd #(
    .NUM_SRC (NUM_SRC),
    .NUM_FWD (NUM_FWD),
    .FWD_MASK(FWD_MASK)
  ) u_fwd (
    .src_i(src_i),
    .fwd_o(fwd_irq_o)
  );
endmodule

// File: rtl/l2irq_checker.sv
module l2irq_checker
  import l2irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 12,
  parameter int unsigned NUM_OUT = 2,
  parameter logic [NUM_OUT*REG_W-1:0] ROUTE_MASKS = {32'h0000_0140, 32'h0000_0EB8}
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_i,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] en_eff,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_OUT-1:0] agg,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [2:0]         bus_addr,
  input logic               suspend
);
  // a blocked source never reaches status
  assert_masked_hidden_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~$past(en_eff)) == '0);

  // status bits only follow sources that were active
  assert_level_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~$past(src_i)) == '0);

  // status offset is not writable
  assert_status_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_STATUS) |=> $stable(en_q));

  // suspend only widens the enable
  assert_suspend_widens_R9: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> ((en_q & ~en_eff) == '0));

  generate
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out_chk
      localparam logic [NUM_SRC-1:0] ROUTE_K = ROUTE_MASKS[k*REG_W +: NUM_SRC];
      assert_out_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        agg[k] |-> (|(status & ROUTE_K)));
    end
  endgenerate
endmodule

bind l2irq_aggregator l2irq_checker #(
  .NUM_SRC    (NUM_SRC),
  .NUM_OUT    (NUM_OUT),
  .ROUTE_MASKS(ROUTE_MASKS)
) u_l2irq_checker (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .src_i   (src_i),
  .en_q    (en_q),
  .en_eff  (en_eff),
  .status  (status_q),
  .agg     (agg_irq_o),
  .bus_sel (bus_sel_i),
  .bus_wr  (bus_wr_i),
  .bus_addr(bus_addr_i),
  .suspend (suspend_i)
);

// File: tb/l2irq_aggregator_bench.sv
module l2irq_aggregator_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VALID   = 32'h0000_0FFF;
  localparam logic [31:0] FWD_A   = 32'h7;
  localparam logic [31:0] FWD_B   = 32'h5;
  localparam logic [31:0] R0_A    = 32'h0EB8;
  localparam logic [31:0] R0_B    = 32'h0EBF;
  localparam logic [31:0] R1_AB   = 32'h0140;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] src = '0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        susp = 1'b0;
  logic [31:0] wake = '0;
  logic [31:0] rdata_a, rdata_b;
  logic [1:0]  agg_a, agg_b;
  logic [2:0]  fwd_a, fwd_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2irq_aggregator u_l2irq_aggregator (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_a),
    .suspend_i(susp), .wake_mask_i(wake), .agg_irq_o(agg_a), .fwd_irq_o(fwd_a)
  );

  l2irq_aggregator #(
    .ROUTE_MASKS({32'h0000_0140, 32'h0000_0EBF}),
    .FWD_MASK   (3'b101)
  ) u_l2irq_aggregator_alt (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_b),
    .suspend_i(susp), .wake_mask_i(wake), .agg_irq_o(agg_b), .fwd_irq_o(fwd_b)
  );

  function automatic logic [31:0] exp_status(logic [31:0] s, logic [31:0] en,
      logic sp, logic [31:0] wk, logic [31:0] fw);
    logic [31:0] eff;
    eff = sp ? (en | fw | wk) : en;
    return s & eff & VALID & ~fw;
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  // combinational read, sampled mid-cycle
  task automatic bus_read(logic [2:0] a, output logic [31:0] da, output logic [31:0] db);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    da = rdata_a; db = rdata_b;
    sel = 1'b0;
  endtask

  task automatic check_all(logic [31:0] en, string tag);
    logic [31:0] ra, rb, ea, eb;
    ea = exp_status({20'h0, src}, en, susp, wake, FWD_A);
    eb = exp_status({20'h0, src}, en, susp, wake, FWD_B);
    bus_read(3'h4, ra, rb);
    chk(ra, ea, {tag, " status A"});
    chk(rb, eb, {tag, " status B"});
    chk({30'h0, agg_a}, {30'h0, |(ea & R1_AB), |(ea & R0_A)}, {tag, " agg A R4"});
    chk({30'h0, agg_b}, {30'h0, |(eb & R1_AB), |(eb & R0_B)}, {tag, " agg B R4"});
    chk({29'h0, fwd_a}, {29'h0, src[2:0] & FWD_A[2:0]}, {tag, " fwd A R5"});
    chk({29'h0, fwd_b}, {29'h0, src[2:0] & FWD_B[2:0]}, {tag, " fwd B R5"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra, rb;
    logic [31:0] en_list [4];
    en_list[0] = 32'hFFF; en_list[1] = 32'hA5A; en_list[2] = 32'h0F0; en_list[3] = 32'h000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: reset contents
    bus_read(3'h0, ra, rb);
    chk(ra, FWD_A, "R8 enable A after reset");
    chk(rb, FWD_B, "R8 enable B after reset");
    bus_read(3'h4, ra, rb);
    chk(ra, 32'h0, "R8 status A after reset");
    chk({30'h0, agg_a, agg_b}, 32'h0, "R8 agg after reset");

    // R1: upper bits dropped
    bus_write(3'h0, 32'hFFFF_FFFF);
    bus_read(3'h0, ra, rb);
    chk(ra, 32'hFFF, "R1 enable readback A");
    chk(rb, 32'hFFF, "R1 enable readback B");

    // R3: writes to status ignored
    bus_write(3'h4, 32'h0000_0000);
    bus_read(3'h0, ra, rb);
    chk(ra, 32'hFFF, "R3 status write ignored A");
    chk(rb, 32'hFFF, "R3 status write ignored B");

    // R10: latency of one edge
    src = 12'h008;
    #1;
    chk({31'h0, agg_a[0]}, 32'h0, "R10 agg before edge");
    @(posedge clk);
    @(negedge clk);
    chk({31'h0, agg_a[0]}, 32'h1, "R10 agg after edge");
    // R7: clears when source drops, no access
    src = 12'h000;
    @(posedge clk);
    @(negedge clk);
    bus_read(3'h4, ra, rb);
    chk(ra, 32'h0, "R7 status cleared A");
    chk({31'h0, agg_a[0]}, 32'h0, "R7 agg cleared A");

    // R2 R3 R4 R5 R6: sweep of all source patterns under several enables
    for (int e = 0; e < 4; e++) begin
      bus_write(3'h0, en_list[e]);
      for (int s = 0; s < 4096; s++) begin
        src = 12'(s);
        @(posedge clk);
        @(negedge clk);
        check_all(en_list[e], "R2 R3 R6 sweep");
      end
    end

    // R9: suspend overlay and restore
    bus_write(3'h0, 32'h0);
    wake = 32'h8000_0020;
    susp = 1'b1;
    src = 12'hFFF;
    repeat (2) @(negedge clk);
    check_all(32'h0, "R9 suspend");
    bus_read(3'h0, ra, rb);
    chk(ra, 32'h0, "R9 stored enable kept A");
    bus_write(3'h0, 32'h100);
    @(negedge clk);
    check_all(32'h100, "R9 write during suspend");
    susp = 1'b0;
    repeat (2) @(negedge clk);
    check_all(32'h100, "R9 restored");
    chk({30'h0, agg_a}, 32'h2, "R9 restored agg A");
    bus_read(3'h0, ra, rb);
    chk(rb, 32'h100, "R9 stored enable B");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule